// File: doc/BRIEF.md
# SECDED Protected Word Memory

This block is a single-port synchronous word memory with 32-bit data words, each stored next to a 7-bit check code. The code corrects any single flipped bit and flags any two flipped bits in a stored word. Requests arrive on a valid/ready channel that carries read, full-word write and partial (byte-enabled) write operations.

A full-word write stores the data and its freshly generated code in the cycle it is accepted. A write with any byte enable low runs a two-cycle read-modify-write. The first cycle reads the stored word and corrects it. The second cycle merges the enabled bytes, re-encodes the merged word and writes it back. The channel is stalled during the second cycle. Read responses appear on a response strobe exactly one cycle after the read is accepted, with corrected data and single-error and double-error pulses.

For fault testing, any write may choose to store a caller-supplied check code instead of the generated one. An enable input switches checking on and off. With checking off, stored data is returned as it is and no error is ever flagged.

Top module: `secded_ram`

## Requirements
- R1: A write with all four byte enables high is accepted in one cycle, stores the data with its generated code, and leaves `req_ready` high in the following cycle; a later read returns the data with both error flags low.
- R2: A read accepted at a clock edge raises `rsp_valid` for exactly the next cycle; `rsp_valid` is never high without such a read. Reads may be issued back to back, one per cycle. The response has no back-pressure, so the consumer must take it in the cycle it appears.
- R3: A write with any byte enable low drops `req_ready` for exactly the one cycle after acceptance. Byte enable bit i selects data bits 8i+7..8i from the request; the other bytes keep the stored (corrected) value. The merged word is re-encoded and written.
- R4: With checking enabled, a stored word containing one flipped bit is read back corrected, with `err_single` high in the response cycle.
- R5: With checking enabled, a stored word containing two flipped bits returns the raw stored data with `err_double` high and `err_single` low. The two flags are never high together.
- R6: With checking disabled, read data is the raw stored data and both error flags stay low.
- R7: When `req_inject` is high on a write, `inj_code` is stored as the check code. The code layout is as follows. Codeword positions 1..38 hold the data bits in ascending order at the positions that are not powers of two, starting with data bit 0 at position 3. Code bit k (k = 0..5) is the even parity of the positions whose index has bit k set. Code bit 6 is the even parity of all 32 data bits and code bits 0..5.
- R8: If the read phase of a partial write finds a double error, the merge uses the raw stored bytes, the write still happens with a freshly generated code, and `err_double` is high in the stall cycle.
- R9: If the read phase of a partial write finds a single error, the merge uses the corrected word and `err_single` is high in the stall cycle.
- R10: The error flags are high only in a response cycle or in a partial-write stall cycle.
- R11: After reset, `req_ready` is high, and `rsp_valid` and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_en | input | 1 | Checking and correction enable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables for writes |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| req_inject | input | 1 | Store `inj_code` instead of the generated code |
| inj_code | input | 7 | Supplied check code |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Read data |
| err_single | output | 1 | Corrected single-bit error pulse |
| err_double | output | 1 | Detected double-bit error pulse |

## Verification
Clean words, words with one flipped data bit, words with one flipped code bit, and words with two flipped bits are all created through the injection path. The bench supplies the code of a neighbouring data value that differs in one or two bits. The one-data-bit case shows whether the correction lands on the right bit, which a flipped code bit alone cannot show. The two-bit case separates a wrong correction from a proper detection. Partial writes over each kind of damaged word tell a merge taken from the corrected word apart from one taken from the raw word. Random mixes of reads, full writes and partial writes with checking toggled add coverage of sequences.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 32;
  localparam int HAM_W  = 6;
  localparam int CODE_W = HAM_W + 1;
  localparam int WORD_W = DATA_W + CODE_W;
  localparam int LAST_POS = DATA_W + HAM_W;
  localparam int BYTES  = DATA_W / 8;

  typedef enum logic { ST_IDLE, ST_MERGE } ctl_state_e;

  // Hamming parity bits over the data placed at non-power-of-two positions.
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int di;
    h  = '0;
    di = 0;
    for (int p = 1; p <= LAST_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int k = 0; k < HAM_W; k++) begin
          if (((p >> k) & 1) == 1) h[k] = h[k] ^ d[di];
        end
        di++;
      end
    end
    return h;
  endfunction

  // Mask selecting the data bit that sits at codeword position syn (zero if none).
  function automatic logic [DATA_W-1:0] pos_to_mask(input logic [HAM_W-1:0] syn);
    logic [DATA_W-1:0] m;
    int di;
    m  = '0;
    di = 0;
    for (int p = 1; p <= LAST_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (p == int'(syn)) m[di] = 1'b1;
        di++;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  logic [HAM_W-1:0] ham;
  always_comb begin
    ham  = ham_bits(data);
    code = {(^data) ^ (^ham), ham};
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic              en,
  input  logic [WORD_W-1:0] word,
  output logic [DATA_W-1:0] data,
  output logic              single,
  output logic              double
);
  logic [DATA_W-1:0] raw;
  logic [CODE_W-1:0] chk;
  logic [HAM_W-1:0]  syn;
  logic              ovr;
  logic              in_range;

  always_comb begin
    raw      = word[DATA_W-1:0];
    chk      = word[WORD_W-1:DATA_W];
    syn      = ham_bits(raw) ^ chk[HAM_W-1:0];
    ovr      = ^word;
    in_range = (int'(syn) <= LAST_POS);
    single   = en && ovr && in_range;
    double   = en && ((!ovr && (syn != '0)) || (ovr && !in_range));
    data     = single ? (raw ^ pos_to_mask(syn)) : raw;
  end
endmodule

// File: rtl/ram_array.sv
module ram_array #(
  parameter int DEPTH = 16,
  parameter int W     = 39,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/secded_ram.sv
module secded_ram
  import secded_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [BYTES-1:0]  req_be,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_inject,
  input  logic [CODE_W-1:0] inj_code,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err_single,
  output logic              err_double
);
  ctl_state_e        state_q;
  logic              rd_q;
  logic [AW-1:0]     addr_q;
  logic [BYTES-1:0]  be_q;
  logic [DATA_W-1:0] wd_q;
  logic              inj_q;
  logic [CODE_W-1:0] code_q;

  logic accept, full_wr, part_wr, merging;
  logic ram_we, ram_re;
  logic [AW-1:0]     ram_addr;
  logic [WORD_W-1:0] ram_wword, ram_rword;
  logic [DATA_W-1:0] dec_data, merged, wr_data;
  logic [CODE_W-1:0] gen_code, sel_code;
  logic              dec_single, dec_double;

  assign req_ready = (state_q == ST_IDLE);
  assign merging   = (state_q == ST_MERGE);
  assign accept    = req_valid && req_ready;
  assign full_wr   = accept && req_we && (&req_be);
  assign part_wr   = accept && req_we && !(&req_be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
    end else begin
      rd_q <= accept && !req_we;
      if (part_wr)      state_q <= ST_MERGE;
      else if (merging) state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (part_wr) begin
      addr_q <= req_addr;
      be_q   <= req_be;
      wd_q   <= req_wdata;
      inj_q  <= req_inject;
      code_q <= inj_code;
    end
  end

  // Merge new bytes into the checked stored word.
  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign merged[8*b+7:8*b] = be_q[b] ? wd_q[8*b+7:8*b] : dec_data[8*b+7:8*b];
  end

  assign wr_data  = merging ? merged : req_wdata;
  assign sel_code = merging ? (inj_q ? code_q : gen_code)
                            : (req_inject ? inj_code : gen_code);
  assign ram_wword = {sel_code, wr_data};
  assign ram_we    = full_wr || merging;
  assign ram_re    = (accept && !req_we) || part_wr;
  assign ram_addr  = merging ? addr_q : req_addr;

  secded_enc u_enc (
    .data (wr_data),
    .code (gen_code)
  );

  ram_array #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata (ram_wword),
    .rdata (ram_rword)
  );

  secded_dec u_dec (
    .en     (ecc_en),
    .word   (ram_rword),
    .data   (dec_data),
    .single (dec_single),
    .double (dec_double)
  );

  assign rsp_valid  = rd_q;
  assign rsp_rdata  = dec_data;
  assign err_single = (rd_q || merging) && dec_single;
  assign err_double = (rd_q || merging) && dec_double;

  p_full_nostall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_we && (&req_be)) |=> req_ready);
  p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_we) |=> rsp_valid);
  p_resp_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_we));
  p_merge_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_we && !(&req_be)) |=> !req_ready);
  p_merge_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);
  p_one_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_single && err_double));
  p_flags_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_en |-> (!err_single && !err_double));
  p_flag_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_single || err_double) |-> (rsp_valid || !req_ready));
endmodule

// File: tb/tb_secded_ram.sv
module tb_secded_ram;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ecc_en = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_we = 1'b0;
  logic [3:0] req_be = 4'hF;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_inject = 1'b0;
  logic [6:0] inj_code = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic err_single, err_double;

  always #10 clk = ~clk;

  secded_ram #(.DEPTH(DEPTH)) dut (.*);

  int checks = 0;
  int errors = 0;

  // Model: data as written, data-domain flip mask, and code-bit flip mask.
  logic [31:0] m_d  [DEPTH];
  logic [31:0] m_mk [DEPTH];
  logic [6:0]  m_cf [DEPTH];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Code per R7: XOR of the codeword positions of the set data bits, plus overall parity.
  function automatic logic [6:0] tb_code(input logic [31:0] d);
    logic [5:0] h;
    int pos;
    h = '0;
    pos = 2;
    for (int i = 0; i < 32; i++) begin
      pos++;
      if ((pos & (pos - 1)) == 0) pos++;
      if (d[i]) h = h ^ pos[5:0];
    end
    return {(^d) ^ (^h), h};
  endfunction

  task automatic exp_word(input int a, input bit en, output logic [31:0] d,
                          output bit e1, output bit e2);
    int pm, pc;
    pm = $countones(m_mk[a]);
    pc = $countones(m_cf[a]);
    d = m_d[a];
    e1 = 0;
    e2 = 0;
    if (en) begin
      if (pm == 1) begin d = m_d[a] ^ m_mk[a]; e1 = 1; end
      else if (pc == 1) e1 = 1;
      else if (pm == 2 || pc == 2) e2 = 1;
    end
  endtask

  task automatic issue(input bit we, input logic [3:0] be, input int a,
                       input logic [31:0] wd, input bit inj, input logic [6:0] cd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_be = be; req_addr = AW'(a);
    req_wdata = wd; req_inject = inj; inj_code = cd;
    @(negedge clk);
    req_valid = 0; req_inject = 0;
  endtask

  task automatic do_read(input int a, input string req);
    logic [31:0] d; bit e1, e2;
    exp_word(a, ecc_en, d, e1, e2);
    issue(0, 4'h0, a, 32'h0, 0, 7'h0);
    check(rsp_valid === 1'b1, "R2", "rsp_valid", 64'(rsp_valid), 64'd1);
    check(rsp_rdata === d, req, "rdata", 64'(rsp_rdata), 64'(d));
    check(err_single === e1, req, "err_single", 64'(err_single), 64'(e1));
    check(err_double === e2, req, "err_double", 64'(err_double), 64'(e2));
  endtask

  // Full write; mk/cf describe an injected code (0 = generated code).
  task automatic do_fwrite(input int a, input logic [31:0] d, input logic [31:0] mk,
                           input logic [6:0] cf, input bit inj);
    issue(1, 4'hF, a, d, inj, tb_code(d ^ mk) ^ cf);
    check(req_ready === 1'b1, "R1", "ready after full write", 64'(req_ready), 64'd1);
    m_d[a] = d; m_mk[a] = inj ? mk : 32'h0; m_cf[a] = inj ? cf : 7'h0;
  endtask

  task automatic do_pwrite(input int a, input logic [3:0] be, input logic [31:0] wd,
                           input logic [31:0] mk, input logic [6:0] cf, input bit inj,
                           input string req);
    logic [31:0] base, mrg; bit e1, e2;
    exp_word(a, ecc_en, base, e1, e2);
    for (int b = 0; b < 4; b++) mrg[8*b +: 8] = be[b] ? wd[8*b +: 8] : base[8*b +: 8];
    issue(1, be, a, wd, inj, tb_code(mrg ^ mk) ^ cf);
    check(req_ready === 1'b0, "R3", "stall cycle ready", 64'(req_ready), 64'd0);
    check(err_single === e1, req, "stall err_single", 64'(err_single), 64'(e1));
    check(err_double === e2, req, "stall err_double", 64'(err_double), 64'(e2));
    check(rsp_valid === 1'b0, "R2", "no rsp on write", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    check(req_ready === 1'b1, "R3", "ready after merge", 64'(req_ready), 64'd1);
    check(err_single === 1'b0 && err_double === 1'b0, "R10", "flags idle",
          64'({err_single, err_double}), 64'd0);
    m_d[a] = mrg; m_mk[a] = inj ? mk : 32'h0; m_cf[a] = inj ? cf : 7'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4417));
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1, "R11", "reset ready", 64'(req_ready), 64'd1);
    check(rsp_valid === 1'b0, "R11", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    check({err_single, err_double} === 2'b00, "R11", "reset flags",
          64'({err_single, err_double}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready === 1'b1 && rsp_valid === 1'b0, "R11", "after reset",
          64'({req_ready, rsp_valid}), 64'b10);

    for (int a = 0; a < DEPTH; a++) do_fwrite(a, 32'hA5000000 + 32'(a * 77), 0, 0, 0);

    // R1 plain round trip
    do_read(3, "R1");
    // R4/R7 one data bit wrong via injected neighbour code
    do_fwrite(1, 32'h12345678, 32'h00010000, 0, 1);
    do_read(1, "R4");
    do_fwrite(2, 32'hFFFFFFFF, 32'h80000000, 0, 1);
    do_read(2, "R4");
    // R7 one code bit flipped
    do_fwrite(4, 32'h0F0F0F0F, 0, 7'h40, 1);
    do_read(4, "R7");
    do_fwrite(5, 32'h00000000, 0, 7'h01, 1);
    do_read(5, "R7");
    // R5 double errors
    do_fwrite(6, 32'hDEADBEEF, 32'h00000011, 0, 1);
    do_read(6, "R5");
    do_fwrite(7, 32'hCAFEF00D, 0, 7'h21, 1);
    do_read(7, "R5");
    // R6 checking disabled
    ecc_en = 0;
    do_read(1, "R6");
    do_read(6, "R6");
    ecc_en = 1;
    // R3 partial on clean word
    do_pwrite(8, 4'b0001, 32'h000000EE, 0, 0, 0, "R3");
    do_read(8, "R3");
    do_pwrite(8, 4'b1100, 32'h77660000, 0, 0, 0, "R3");
    do_read(8, "R3");
    // R8 partial over a double error
    do_pwrite(6, 4'b0010, 32'h00009900, 0, 0, 0, "R8");
    do_read(6, "R8");
    // R9 partial over a single data error
    do_pwrite(1, 4'b1000, 32'h3C000000, 0, 0, 0, "R9");
    do_read(1, "R9");
    // R2 back-to-back reads
    begin
      logic [31:0] d0, d1; bit a1, a2, b1, b2;
      exp_word(3, 1, d0, a1, a2);
      exp_word(4, 1, d1, b1, b2);
      @(negedge clk);
      req_valid = 1; req_we = 0; req_addr = 3;
      @(negedge clk);
      check(rsp_valid === 1'b1 && rsp_rdata === d0, "R2", "first of pair",
            64'(rsp_rdata), 64'(d0));
      req_addr = 4;
      @(negedge clk);
      req_valid = 0;
      check(rsp_valid === 1'b1 && rsp_rdata === d1 && err_single === b1, "R2",
            "second of pair", 64'(rsp_rdata), 64'(d1));
      @(negedge clk);
      check(rsp_valid === 1'b0, "R2", "pulse ends", 64'(rsp_valid), 64'd0);
    end

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int a, op, kind, i, j;
      logic [31:0] d, mk;
      logic [6:0] cf;
      bit inj;
      a = int'($urandom % DEPTH);
      op = int'($urandom % 3);
      kind = int'($urandom % 5);
      d = $urandom;
      i = int'($urandom % 32);
      j = (i + 1 + int'($urandom % 31)) % 32;
      mk = 0; cf = 0; inj = $urandom % 2;
      if (kind == 2) mk = 32'h1 << i;
      else if (kind == 3) mk = (32'h1 << i) | (32'h1 << j);
      else if (kind == 4) begin
        cf = 7'h1 << (i % 7);
        if ($urandom % 2) cf = cf | (7'h1 << ((i + 3) % 7));
      end
      if (kind >= 2) inj = 1;
      ecc_en = ($urandom % 5) != 0;
      if (op == 0) do_read(a, "R10");
      else if (op == 1) do_fwrite(a, d, mk, cf, inj);
      else do_pwrite(a, 4'($urandom % 15), d, mk, cf, inj, "R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule